// File: doc/BRIEF.md
# Bus Cycle Sequencer with Address Formation

This block owns the external bus of a processor front end. It chooses the next bus cycle and drives it. There are two sources of work. One is instruction prefetch, which fills a byte queue two bytes at a time. The other is operand traffic from the execution side, which reads or writes memory or I/O.

Every cycle forms a 20-bit physical address. The segment value is shifted left by four bits and the offset is added to it. Each cycle then runs a fixed sequence of four states: address, strobe on, data, and strobe off. One idle state separates one cycle from the next, and the next grant is decided in that idle state.

The code-segment and instruction-pointer pair is held inside the block. The pointer advances after every fetch that is delivered. A redirect reloads the pair, flushes the queue and discards a fetch that is still in flight.

Top module: `busseq_top`

## Requirements
- R1: After reset, the bus is idle: all four strobes are low, `bus_addr` is 0 and `fetch_valid` and `op_done` are low. The first fetch uses segment 16'hFFFF with offset 0, which gives address 20'hFFFF0.
- R2: The address of every cycle is (segment << 4) + offset, kept to its low 20 bits. A fetch uses the code segment and the instruction pointer. An operand cycle uses `op_seg` and `op_off`.
- R3: `bus_addr` carries the cycle address one state before the strobe rises and is unchanged while the strobe is high. The strobe stays high for exactly two clock cycles. Read data is sampled at the end of the second of those cycles.
- R4: A fetch is a memory read. In the state after the strobe falls, it presents the sampled 16-bit word on `fetch_data` with a one-cycle `fetch_valid`. The offset then advances by 2, wrapping within 16 bits.
- R5: No fetch cycle starts while `q_room` is low.
- R6: When `op_req` and `q_room` are both high at an idle boundary, the operand cycle is granted first.
- R7: A fetch that has started runs to completion. An operand request raised during the fetch starts only after that fetch has been delivered.
- R8: An operand cycle drives exactly one strobe, chosen by {`op_io`,`op_write`}: 00 `mem_rd`, 01 `mem_wr`, 10 `io_rd`, 11 `io_wr`. During a write strobe, `bus_doe` is high and `bus_dout` equals `op_wdata`.
- R9: `op_done` pulses for one cycle in the state after the strobe falls. For a read, `op_rdata` carries the sampled word. From an idle bus, `op_done` appears four clocks after `op_req` is first sampled.
- R10: `redir_valid` raises `flush` in the same cycle and loads the new segment and offset. A fetch in flight is not delivered, and fetching resumes at the new target.
- R11: At most one of the four strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| q_room | input | 1 | Queue can accept one more fetched word |
| redir_valid | input | 1 | Control transfer: load new fetch target |
| redir_seg | input | 16 | New code segment |
| redir_off | input | 16 | New instruction offset |
| op_req | input | 1 | Operand cycle requested; held until `op_done` |
| op_write | input | 1 | 1 = write, 0 = read |
| op_io | input | 1 | 1 = I/O space, 0 = memory |
| op_seg | input | 16 | Operand segment |
| op_off | input | 16 | Operand offset |
| op_wdata | input | 16 | Operand write data |
| op_done | output | 1 | Operand cycle finished |
| op_rdata | output | 16 | Operand read data, valid with `op_done` |
| fetch_valid | output | 1 | Fetched word is ready for the queue |
| fetch_data | output | 16 | Fetched word (two instruction bytes) |
| flush | output | 1 | Queue must discard its contents |
| bus_addr | output | 20 | Physical address of the current cycle |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| bus_dout | output | 16 | Write data to the bus |
| bus_doe | output | 1 | Write data is being driven |
| bus_din | input | 16 | Read data from the bus |

## Verification
Two events can compete for the same idle boundary: a prefetch grant and an operand grant. The bench raises `op_req` and `q_room` on the same edge of an idle bus, and then raises `op_req` while a fetch strobe is already high. An ordered scoreboard of expected bus cycles checks that the operand goes first in the first case and the fetch goes first in the second. A redirect can also coincide with a fetch in flight. The bench fires it during a fetch strobe and checks that no stale word is pushed and that the next cycle uses the new target.

// File: rtl/busseq_pkg.sv
package busseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADDR = 3'd1,
        ST_STRB = 3'd2,
        ST_DATA = 3'd3,
        ST_DONE = 3'd4
    } bstate_e;

    typedef enum logic {
        K_FETCH = 1'b0,
        K_OPER  = 1'b1
    } bkind_e;

    localparam int unsigned NUM_STROBES = 4;

endpackage

// File: rtl/busseq_phys.sv
module busseq_phys #(
    parameter int unsigned SEG_W  = 16,
    parameter int unsigned OFF_W  = 16,
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned SHIFT  = 4
) (
    input  logic [SEG_W-1:0]  seg,
    input  logic [OFF_W-1:0]  off,
    output logic [ADDR_W-1:0] phys
);
    localparam int unsigned EXT_W = (SEG_W + SHIFT > ADDR_W) ? SEG_W + SHIFT : ADDR_W;

    logic [EXT_W-1:0] seg_ext;
    logic [EXT_W-1:0] off_ext;
    logic [EXT_W-1:0] sum;

    always_comb begin
        seg_ext = EXT_W'(seg) << SHIFT;
        off_ext = EXT_W'(off);
        sum     = seg_ext + off_ext;
        phys    = sum[ADDR_W-1:0];
    end
endmodule

// File: rtl/busseq_fetch_ptr.sv
module busseq_fetch_ptr #(
    parameter int unsigned SEG_W     = 16,
    parameter int unsigned OFF_W     = 16,
    parameter int unsigned STEP      = 2,
    parameter int unsigned RESET_SEG = 'hFFFF,
    parameter int unsigned RESET_OFF = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             redir_valid,
    input  logic [SEG_W-1:0] redir_seg,
    input  logic [OFF_W-1:0] redir_off,
    input  logic             advance,
    output logic [SEG_W-1:0] cs,
    output logic [OFF_W-1:0] ip
);
    typedef struct packed {
        logic [SEG_W-1:0] cs;
        logic [OFF_W-1:0] ip;
    } ptr_s;

    ptr_s ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (redir_valid) begin
            ptr_d.cs = redir_seg;
            ptr_d.ip = redir_off;
        end else if (advance) begin
            ptr_d.ip = ptr_q.ip + OFF_W'(STEP);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q.cs <= SEG_W'(RESET_SEG);
            ptr_q.ip <= OFF_W'(RESET_OFF);
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign cs = ptr_q.cs;
    assign ip = ptr_q.ip;

    assert_ip_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !redir_valid) |=> (ip == $past(ip) + OFF_W'(STEP)))
        else $error("instruction pointer did not advance by one word");

    assert_redir_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> (cs == $past(redir_seg) && ip == $past(redir_off)))
        else $error("redirect target not loaded");
endmodule

// File: rtl/busseq_strobe_dec.sv
module busseq_strobe_dec
    import busseq_pkg::*;
(
    input  logic                   active,
    input  logic                   is_write,
    input  logic                   is_io,
    output logic [NUM_STROBES-1:0] strobe
);
    // index = {is_io, is_write}: 0 mem read, 1 mem write, 2 io read, 3 io write
    logic [1:0] sel;
    assign sel = {is_io, is_write};

    for (genvar g = 0; g < NUM_STROBES; g++) begin : g_strb
        assign strobe[g] = active && (sel == 2'(g));
    end
endmodule

// File: rtl/busseq_top.sv
module busseq_top
    import busseq_pkg::*;
#(
    parameter int unsigned SEG_W     = 16,
    parameter int unsigned OFF_W     = 16,
    parameter int unsigned ADDR_W    = 20,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned SEG_SHIFT = 4,
    parameter int unsigned RESET_SEG = 'hFFFF,
    parameter int unsigned RESET_OFF = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_room,
    input  logic              redir_valid,
    input  logic [SEG_W-1:0]  redir_seg,
    input  logic [OFF_W-1:0]  redir_off,
    input  logic              op_req,
    input  logic              op_write,
    input  logic              op_io,
    input  logic [SEG_W-1:0]  op_seg,
    input  logic [OFF_W-1:0]  op_off,
    input  logic [DATA_W-1:0] op_wdata,
    output logic              op_done,
    output logic [DATA_W-1:0] op_rdata,
    output logic              fetch_valid,
    output logic [DATA_W-1:0] fetch_data,
    output logic              flush,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              io_rd,
    output logic              io_wr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    input  logic [DATA_W-1:0] bus_din
);
    localparam int unsigned FETCH_STEP = DATA_W / 8;

    typedef struct packed {
        bstate_e             st;
        bkind_e              kind;
        logic                wr;
        logic                io;
        logic                cancel;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic [DATA_W-1:0]   rdata;
    } seq_s;

    seq_s seq_d, seq_q;

    logic [SEG_W-1:0]       cs;
    logic [OFF_W-1:0]       ip;
    logic [ADDR_W-1:0]      fetch_phys;
    logic [ADDR_W-1:0]      op_phys;
    logic                   strobe_on;
    logic [NUM_STROBES-1:0] strobes;
    logic                   any_strobe;
    logic                   fetch_ok;

    busseq_phys #(
        .SEG_W (SEG_W), .OFF_W (OFF_W), .ADDR_W (ADDR_W), .SHIFT (SEG_SHIFT)
    ) u_fetch_phys (
        .seg (cs), .off (ip), .phys (fetch_phys)
    );

    busseq_phys #(
        .SEG_W (SEG_W), .OFF_W (OFF_W), .ADDR_W (ADDR_W), .SHIFT (SEG_SHIFT)
    ) u_op_phys (
        .seg (op_seg), .off (op_off), .phys (op_phys)
    );

    busseq_fetch_ptr #(
        .SEG_W (SEG_W), .OFF_W (OFF_W), .STEP (FETCH_STEP),
        .RESET_SEG (RESET_SEG), .RESET_OFF (RESET_OFF)
    ) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .redir_valid (redir_valid),
        .redir_seg   (redir_seg),
        .redir_off   (redir_off),
        .advance     (fetch_ok),
        .cs          (cs),
        .ip          (ip)
    );

    assign strobe_on = (seq_q.st == ST_STRB) || (seq_q.st == ST_DATA);

    busseq_strobe_dec u_dec (
        .active   (strobe_on),
        .is_write (seq_q.wr),
        .is_io    (seq_q.io),
        .strobe   (strobes)
    );

    // next-state: grant only from idle; operand wins over prefetch
    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (op_req) begin
                    seq_d.st     = ST_ADDR;
                    seq_d.kind   = K_OPER;
                    seq_d.wr     = op_write;
                    seq_d.io     = op_io;
                    seq_d.addr   = op_phys;
                    seq_d.wdata  = op_wdata;
                    seq_d.cancel = 1'b0;
                end else if (q_room && !redir_valid) begin
                    seq_d.st     = ST_ADDR;
                    seq_d.kind   = K_FETCH;
                    seq_d.wr     = 1'b0;
                    seq_d.io     = 1'b0;
                    seq_d.addr   = fetch_phys;
                    seq_d.wdata  = '0;
                    seq_d.cancel = 1'b0;
                end
            end
            ST_ADDR: seq_d.st = ST_STRB;
            ST_STRB: seq_d.st = ST_DATA;
            ST_DATA: begin
                seq_d.st    = ST_DONE;
                seq_d.rdata = bus_din;
            end
            ST_DONE: seq_d.st = ST_IDLE;
            default: seq_d.st = ST_IDLE;
        endcase
        if (seq_q.st != ST_IDLE && seq_q.kind == K_FETCH && redir_valid) begin
            seq_d.cancel = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, kind: K_FETCH, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign fetch_ok    = (seq_q.st == ST_DONE) && (seq_q.kind == K_FETCH)
                         && !seq_q.cancel && !redir_valid;
    assign fetch_valid = fetch_ok;
    assign fetch_data  = seq_q.rdata;
    assign op_done     = (seq_q.st == ST_DONE) && (seq_q.kind == K_OPER);
    assign op_rdata    = (op_done && !seq_q.wr) ? seq_q.rdata : '0;
    assign flush       = redir_valid;
    assign bus_addr    = (seq_q.st != ST_IDLE) ? seq_q.addr : '0;
    assign mem_rd      = strobes[0];
    assign mem_wr      = strobes[1];
    assign io_rd       = strobes[2];
    assign io_wr       = strobes[3];
    assign bus_doe     = strobe_on && seq_q.wr;
    assign bus_dout    = bus_doe ? seq_q.wdata : '0;
    assign any_strobe  = |strobes;

    assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr, io_rd, io_wr}))
        else $error("more than one strobe active");

    assert_strobe_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(any_strobe) |-> $past(any_strobe, 2))
        else $error("strobe shorter than two cycles");

    assert_addr_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(any_strobe) |-> $stable(bus_addr))
        else $error("address changed as strobe rose");

    assert_op_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_IDLE && op_req && q_room) |=> (seq_q.kind == K_OPER && seq_q.st == ST_ADDR))
        else $error("prefetch granted ahead of operand");

    assert_no_room_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_IDLE && !q_room && !op_req) |=> (seq_q.st == ST_IDLE))
        else $error("cycle started without queue room");

    assert_no_push_redir_R10: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> !fetch_valid)
        else $error("fetch delivered during redirect");
endmodule

// File: tb/busseq_top_test.sv
module busseq_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        q_room = 1'b0;
    logic        redir_valid = 1'b0;
    logic [15:0] redir_seg = '0;
    logic [15:0] redir_off = '0;
    logic        op_req = 1'b0;
    logic        op_write = 1'b0;
    logic        op_io = 1'b0;
    logic [15:0] op_seg = '0;
    logic [15:0] op_off = '0;
    logic [15:0] op_wdata = '0;
    logic        op_done;
    logic [15:0] op_rdata;
    logic        fetch_valid;
    logic [15:0] fetch_data;
    logic        flush;
    logic [19:0] bus_addr;
    logic        mem_rd, mem_wr, io_rd, io_wr;
    logic [15:0] bus_dout;
    logic        bus_doe;
    logic [15:0] bus_din;

    always #10 clk = ~clk;

    busseq_top uut (
        .clk(clk), .rst_n(rst_n), .q_room(q_room),
        .redir_valid(redir_valid), .redir_seg(redir_seg), .redir_off(redir_off),
        .op_req(op_req), .op_write(op_write), .op_io(op_io),
        .op_seg(op_seg), .op_off(op_off), .op_wdata(op_wdata),
        .op_done(op_done), .op_rdata(op_rdata),
        .fetch_valid(fetch_valid), .fetch_data(fetch_data), .flush(flush),
        .bus_addr(bus_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .io_rd(io_rd), .io_wr(io_wr), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .bus_din(bus_din)
    );

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
        return {s, 4'h0} + {4'h0, o};
    endfunction

    function automatic logic [15:0] memval(input logic [19:0] a, input logic io);
        return a[15:0] ^ 16'h5A3C ^ (io ? 16'hFFFF : 16'h0000);
    endfunction

    assign bus_din = (mem_rd || io_rd) ? memval(bus_addr, io_rd) : 16'h0000;

    // kind: 0 fetch, 1 mem read, 2 mem write, 3 io read, 4 io write
    typedef struct {
        int          kind;
        logic [19:0] addr;
        logic [15:0] wdata;
    } item_t;

    item_t       exp_q[$];
    int          checks = 0;
    int          fails = 0;
    int          fetch_cnt = 0;
    int          strobe_starts = 0;
    bit          finished = 0;
    logic [15:0] m_cs = 16'hFFFF;
    logic [15:0] m_ip = 16'h0000;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic push_fetch();
        item_t it;
        it.kind = 0; it.addr = phys(m_cs, m_ip); it.wdata = '0;
        exp_q.push_back(it);
        m_ip = m_ip + 16'd2;
    endtask

    // scoreboard monitor
    logic        prev_any = 1'b0;
    logic [19:0] prev_addr = '0;
    int          run = 0;
    logic [19:0] last_fetch_addr = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            automatic logic any = mem_rd | mem_wr | io_rd | io_wr;
            automatic int   code = mem_rd ? 1 : mem_wr ? 2 : io_rd ? 3 : io_wr ? 4 : 0;
            chk("R11", "strobe count", 32'($countones({mem_rd, mem_wr, io_rd, io_wr}) <= 1), 32'd1);
            if (any && !prev_any) begin
                item_t it;
                strobe_starts++;
                run = 1;
                chk("R3", "address ahead of strobe", 32'(prev_addr), 32'(bus_addr));
                if (exp_q.size() == 0) begin
                    chk("R7", "unexpected bus cycle", 32'(code), 32'd0);
                end else begin
                    it = exp_q.pop_front();
                    chk("R8", "cycle kind", 32'(code), 32'((it.kind == 0) ? 1 : it.kind));
                    chk("R2", "cycle address", 32'(bus_addr), 32'(it.addr));
                    if (it.kind == 0) last_fetch_addr = it.addr;
                    if (it.kind == 2 || it.kind == 4) begin
                        chk("R8", "write enable", 32'(bus_doe), 32'd1);
                        chk("R8", "write data", 32'(bus_dout), 32'(it.wdata));
                    end
                end
            end else if (any) begin
                run++;
            end else if (prev_any) begin
                chk("R3", "strobe width", 32'(run), 32'd2);
            end
            if (fetch_valid) begin
                fetch_cnt++;
                chk("R4", "fetch word", 32'(fetch_data), 32'(memval(last_fetch_addr, 1'b0)));
            end
            prev_any  = any;
            prev_addr = bus_addr;
        end
    end

    task automatic run_fetches(input int n);
        int target;
        for (int i = 0; i < n; i++) push_fetch();
        target = fetch_cnt + n;
        @(negedge clk); #1;
        q_room = 1'b1;
        while (fetch_cnt < target) begin
            @(negedge clk); #1;
        end
        q_room = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_op(input logic wr, input logic io, input logic [15:0] s,
                         input logic [15:0] o, input logic [15:0] wd, input bit chk_lat);
        item_t it;
        int    lat;
        it.kind = 1 + (io ? 2 : 0) + (wr ? 1 : 0);
        it.addr = phys(s, o); it.wdata = wd;
        exp_q.push_back(it);
        @(negedge clk); #1;
        op_write = wr; op_io = io; op_seg = s; op_off = o; op_wdata = wd; op_req = 1'b1;
        lat = 0;
        do begin
            @(negedge clk); #1;
            lat++;
        end while (!op_done && lat < 50);
        if (chk_lat) chk("R9", "done latency", 32'(lat), 32'd4);
        if (!wr) chk("R9", "read data", 32'(op_rdata), 32'(memval(it.addr, io)));
        op_req = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int start_strobes;
        int saved;
        item_t it;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "strobes in reset", 32'({mem_rd, mem_wr, io_rd, io_wr}), 32'd0);
        chk("R1", "addr in reset", 32'(bus_addr), 32'd0);
        chk("R1", "valid/done in reset", 32'({fetch_valid, op_done}), 32'd0);
        #1 rst_n = 1'b1;

        // R5: no room, nothing happens
        start_strobes = strobe_starts;
        repeat (10) @(negedge clk);
        chk("R5", "no cycle without room", 32'(strobe_starts - start_strobes), 32'd0);

        // R1/R4: fetches from the reset target with step 2
        run_fetches(3);

        // R8/R9/R2: each operand kind, one with segment wrap
        do_op(1'b0, 1'b0, 16'h1234, 16'h0010, 16'h0000, 1'b1);
        do_op(1'b1, 1'b0, 16'hFFFF, 16'h0020, 16'hBEEF, 1'b1);
        do_op(1'b0, 1'b1, 16'h0000, 16'h0060, 16'h0000, 1'b1);
        do_op(1'b1, 1'b1, 16'h00F0, 16'hFF00, 16'hC0DE, 1'b1);

        // R6: operand and prefetch both pending at an idle boundary
        it.kind = 1; it.addr = phys(16'h2000, 16'h0100); it.wdata = '0;
        exp_q.push_back(it);
        push_fetch();
        saved = fetch_cnt;
        @(negedge clk); #1;
        op_write = 1'b0; op_io = 1'b0; op_seg = 16'h2000; op_off = 16'h0100;
        op_req = 1'b1; q_room = 1'b1;
        while (!op_done) begin
            @(negedge clk); #1;
        end
        chk("R6", "no fetch before operand", 32'(fetch_cnt - saved), 32'd0);
        op_req = 1'b0;
        while (fetch_cnt < saved + 1) begin
            @(negedge clk); #1;
        end
        q_room = 1'b0;
        repeat (3) @(negedge clk);

        // R7: operand raised while a fetch strobe is high
        push_fetch();
        it.kind = 3; it.addr = phys(16'h0000, 16'h0044); it.wdata = '0;
        exp_q.push_back(it);
        saved = fetch_cnt;
        @(negedge clk); #1;
        q_room = 1'b1;
        while (!mem_rd) begin
            @(negedge clk); #1;
        end
        op_io = 1'b1; op_write = 1'b0; op_seg = 16'h0000; op_off = 16'h0044;
        op_req = 1'b1; q_room = 1'b0;
        while (!op_done) begin
            @(negedge clk); #1;
        end
        chk("R7", "fetch finished before operand", 32'(fetch_cnt - saved), 32'd1);
        chk("R9", "io read data", 32'(op_rdata), 32'(memval(it.addr, 1'b1)));
        op_req = 1'b0; op_io = 1'b0;
        repeat (3) @(negedge clk);

        // R10: redirect during a fetch strobe, target offset wraps
        push_fetch();
        @(negedge clk); #1;
        q_room = 1'b1;
        while (!mem_rd) begin
            @(negedge clk); #1;
        end
        redir_seg = 16'h0400; redir_off = 16'hFFFE; redir_valid = 1'b1;
        #1 chk("R10", "flush with redirect", 32'(flush), 32'd1);
        m_cs = 16'h0400; m_ip = 16'hFFFE;
        push_fetch();
        push_fetch();
        saved = fetch_cnt;
        @(negedge clk); #1;
        redir_valid = 1'b0;
        chk("R10", "flush released", 32'(flush), 32'd0);
        while (fetch_cnt < saved + 2) begin
            @(negedge clk); #1;
        end
        q_room = 1'b0;
        repeat (8) @(negedge clk);
        chk("R10", "all expected cycles seen", 32'(exp_q.size()), 32'd0);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R4 watchdog actual=hung expected=complete");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule